// File: doc/BRIEF.md
# Cascaded DMA Service Sequencer

This block decides which of eight DMA channels is served when the host bus grants hold, and runs that one transfer. The channels form two banks of four. Channels 0-3 move bytes. Channels 4-7 move 16-bit words and take their address in word units.

The channel registers are kept outside the block. The block reads each channel's mask, mode, page, base and current address, and base and current count from flat input vectors. When a transfer completes, it reports the new address and count so the owning register file can store them. The block itself holds two things:
- the per-channel request flags, which follow the DRQ lines;
- the sticky terminal-count flags.

A hold-acknowledge pulse starts one service walk through four states:
1. Idle.
2. Arbitrate.
3. Transfer, a one-cycle strobe carrying the physical address, direction, width, the acknowledge line and possibly terminal count.
4. Done, which reports the update.

A channel whose mode or programmed region is illegal gets an error pulse instead of a transfer.

Top module: `dma_cascade_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is zero, including `status_o`.
- R2: Request flags follow DRQ.
  - Each channel's request flag equals its `drq_i` one cycle earlier.
  - `status_o` holds 8 bits per bank, with bank 0 in bits 7:0 and bank 1 in bits 15:8.
  - Within a bank, bits 3:0 are the terminal-count flags and bits 7:4 are the request flags, both indexed by local channel.
  - `hrq_o` is registered from "any channel with its request flag set and its mask clear".
- R3: On arbitration the lowest-numbered eligible channel wins, so bank 0 always beats bank 1. An eligible channel has its request flag set and its mask clear. `dack_o` bit n is set for global channel n.
- R4: A hold-acknowledge with no eligible channel produces neither a transfer nor an error.
- R5: The physical address is `{page, 16'h0}` ORed with the current address. On channels 4-7 the current address is first shifted left by one, so its top bit lands on page bit 0.
- R6: In the cycle after the strobe, `upd_o` is high and reports:
  - the channel;
  - the current address plus one;
  - the current count minus one, modulo 2^16.
- R7: When the current count is 0 and auto-reload is off, the transfer has expired.
  - `tc_o` is high together with the strobe.
  - On the next cycle the channel's terminal-count flag is set, and both `dack_o` and `hrq_o` are low.
- R8: When the current count is 0 and auto-reload is on, the update reports the base address and base count, and `tc_o` stays low.
- R9: `to_mem_o` is 1 for transfer type 1 (I/O to memory) and 0 for type 2 (memory to I/O). `wide_o` is 1 exactly for channels 4-7.
- R10: If the sum of base address and base count exceeds 0xFFFF, the channel raises `err_o` for one cycle in place of a transfer.
- R11: Mode bits per channel are:
  - bits 5:4: kind, 00 demand, 01 single;
  - bit 3: decrement;
  - bit 2: auto-reload;
  - bits 1:0: transfer type.

  Any other kind, decrement set, or type 0 or 3 raises `err_o` in place of a transfer.
- R12: The cycle timing is fixed.
  - A `hlda_i` sampled high in idle puts the strobe on the outputs two clock edges later.
  - `upd_o` follows on the next edge.
  - The block is idle again one edge after that.
  - The strobe and `upd_o` are single-cycle pulses.
- R13: `hlda_i` is ignored while a service walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drq_i | input | 8 | Request line per global channel |
| hlda_i | input | 1 | Hold-acknowledge pulse starting a service walk |
| mask_i | input | 8 | Mask per channel, 1 blocks service |
| mode_i | input | 48 | 6 mode bits per channel |
| page_i | input | 64 | 8-bit page per channel |
| base_addr_i | input | 128 | 16-bit base address per channel |
| cur_addr_i | input | 128 | 16-bit current address per channel |
| base_cnt_i | input | 128 | 16-bit base count per channel |
| cur_cnt_i | input | 128 | 16-bit current count per channel |
| hrq_o | output | 1 | Hold request |
| xfer_o | output | 1 | One-cycle transfer strobe |
| dack_o | output | 8 | Acknowledge line of the served channel |
| tc_o | output | 1 | Terminal count, with the strobe |
| phys_o | output | 24 | Physical address of the transfer |
| to_mem_o | output | 1 | 1 for I/O to memory, 0 for memory to I/O |
| wide_o | output | 1 | 1 for a 16-bit transfer |
| err_o | output | 1 | Illegal mode or region on the picked channel |
| upd_o | output | 1 | Address/count update valid |
| upd_ch_o | output | 3 | Channel being updated |
| upd_addr_o | output | 16 | New current address |
| upd_cnt_o | output | 16 | New current count |
| status_o | output | 16 | Request and terminal-count flags, both banks |

## Verification
A wrong request or terminal-count flag shows on `status_o` on the very next cycle. The same flag also skews `hrq_o` one cycle after that, before any hold-acknowledge arrives.

A wrong arbitration pick, or a wrong latched selection, appears on `dack_o`, `phys_o`, `to_mem_o` and `wide_o` in the strobe cycle, two edges after the acknowledge. A wrong address, count or reload decision stays hidden until the following `upd_o` cycle. It is therefore compared on every update, and it also changes the next transfer's address and terminal-count timing.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int MODE_W = 6;

  typedef struct packed {
    logic [1:0] kind;
    logic       down;
    logic       reload;
    logic [1:0] xtype;
  } chan_mode_t;

  localparam logic [1:0] KIND_DEMAND = 2'b00;
  localparam logic [1:0] KIND_SINGLE = 2'b01;
  localparam logic [1:0] XT_TO_MEM   = 2'b01;
  localparam logic [1:0] XT_FROM_MEM = 2'b10;

  function automatic logic mode_ok(input chan_mode_t m);
    logic kind_good;
    logic type_good;
    kind_good = (m.kind == KIND_DEMAND) || (m.kind == KIND_SINGLE);
    type_good = (m.xtype == XT_TO_MEM) || (m.xtype == XT_FROM_MEM);
    return kind_good && type_good && !m.down;
  endfunction

endpackage

// File: rtl/dma_req_status.sv
`timescale 1ns/1ps
module dma_req_status #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] drq_i,
  input  logic [NUM_CH-1:0] tc_set_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] tc_o
);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
      logic req_q;
      logic tc_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          req_q <= 1'b0;
          tc_q  <= 1'b0;
        end else begin
          req_q <= drq_i[g];
          if (tc_set_i[g]) tc_q <= 1'b1;
        end
      end
      assign req_o[g] = req_q;
      assign tc_o[g]  = tc_q;
    end
  endgenerate

endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] elig_i,
  output logic              found_o,
  output logic [CH_W-1:0]   idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma_chan_calc.sv
`timescale 1ns/1ps
module dma_chan_calc #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] cur_a_i,
  input  logic [ADDR_W-1:0] base_c_i,
  input  logic [ADDR_W-1:0] cur_c_i,
  input  logic              wide_i,
  input  logic              reload_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic [ADDR_W-1:0] nxt_a_o,
  output logic [ADDR_W-1:0] nxt_c_o,
  output logic              stop_o,
  output logic              cross_o
);

  logic [ADDR_W:0] roof;
  logic            wrap;

  assign roof    = {1'b0, base_a_i} + {1'b0, base_c_i};
  assign cross_o = roof[ADDR_W];
  assign phys_o  = {page_i, {ADDR_W{1'b0}}} | ({{PAGE_W{1'b0}}, cur_a_i} << wide_i);
  assign wrap    = (cur_c_i == '0);
  assign stop_o  = wrap && !reload_i;

  always_comb begin
    if (wrap && reload_i) begin
      nxt_a_o = base_a_i;
      nxt_c_o = base_c_i;
    end else begin
      nxt_a_o = cur_a_i + 1'b1;
      nxt_c_o = cur_c_i - 1'b1;
    end
  end

endmodule

// File: rtl/dma_cascade_seq.sv
`timescale 1ns/1ps
module dma_cascade_seq
  import dma_seq_pkg::*;
#(
  parameter int CH_PER_CTL = 4,
  parameter int NUM_CTL    = 2,
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  localparam int NUM_CH    = CH_PER_CTL * NUM_CTL,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int PHYS_W    = PAGE_W + ADDR_W,
  localparam int STAT_W    = NUM_CTL * 2 * CH_PER_CTL
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          drq_i,
  input  logic                       hlda_i,
  input  logic [NUM_CH-1:0]          mask_i,
  input  logic [NUM_CH*MODE_W-1:0]   mode_i,
  input  logic [NUM_CH*PAGE_W-1:0]   page_i,
  input  logic [NUM_CH*ADDR_W-1:0]   base_addr_i,
  input  logic [NUM_CH*ADDR_W-1:0]   cur_addr_i,
  input  logic [NUM_CH*ADDR_W-1:0]   base_cnt_i,
  input  logic [NUM_CH*ADDR_W-1:0]   cur_cnt_i,
  output logic                       hrq_o,
  output logic                       xfer_o,
  output logic [NUM_CH-1:0]          dack_o,
  output logic                       tc_o,
  output logic [PHYS_W-1:0]          phys_o,
  output logic                       to_mem_o,
  output logic                       wide_o,
  output logic                       err_o,
  output logic                       upd_o,
  output logic [CH_W-1:0]            upd_ch_o,
  output logic [ADDR_W-1:0]          upd_addr_o,
  output logic [ADDR_W-1:0]          upd_cnt_o,
  output logic [STAT_W-1:0]          status_o
);

  seq_state_e        state_q;
  logic [NUM_CH-1:0] req_v;
  logic [NUM_CH-1:0] tc_v;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] tc_set;
  logic              found;
  logic [CH_W-1:0]   pick;

  chan_mode_t        sel_mode;
  logic [PAGE_W-1:0] sel_page;
  logic [ADDR_W-1:0] sel_base_a;
  logic [ADDR_W-1:0] sel_cur_a;
  logic [ADDR_W-1:0] sel_base_c;
  logic [ADDR_W-1:0] sel_cur_c;
  logic              sel_wide;

  logic [PHYS_W-1:0] calc_phys;
  logic [ADDR_W-1:0] calc_nxt_a;
  logic [ADDR_W-1:0] calc_nxt_c;
  logic              calc_stop;
  logic              calc_cross;

  logic              hrq_q;
  logic              xfer_q;
  logic [NUM_CH-1:0] dack_q;
  logic              tc_q;
  logic [PHYS_W-1:0] phys_q;
  logic              to_mem_q;
  logic              wide_q;
  logic              err_q;
  logic              upd_q;
  logic [CH_W-1:0]   upd_ch_q;
  logic [ADDR_W-1:0] upd_addr_q;
  logic [ADDR_W-1:0] upd_cnt_q;

  logic [CH_W-1:0]   s_ch;
  logic              s_stop;
  logic [ADDR_W-1:0] s_nxt_a;
  logic [ADDR_W-1:0] s_nxt_c;

  dma_req_status #(.NUM_CH(NUM_CH)) u_status (
    .clk      (clk),
    .rst      (rst),
    .drq_i    (drq_i),
    .tc_set_i (tc_set),
    .req_o    (req_v),
    .tc_o     (tc_v)
  );

  assign elig = req_v & ~mask_i;

  dma_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .elig_i  (elig),
    .found_o (found),
    .idx_o   (pick)
  );

  assign sel_mode   = chan_mode_t'(mode_i[int'(pick)*MODE_W +: MODE_W]);
  assign sel_page   = page_i[int'(pick)*PAGE_W +: PAGE_W];
  assign sel_base_a = base_addr_i[int'(pick)*ADDR_W +: ADDR_W];
  assign sel_cur_a  = cur_addr_i[int'(pick)*ADDR_W +: ADDR_W];
  assign sel_base_c = base_cnt_i[int'(pick)*ADDR_W +: ADDR_W];
  assign sel_cur_c  = cur_cnt_i[int'(pick)*ADDR_W +: ADDR_W];
  assign sel_wide   = (int'(pick) >= CH_PER_CTL);

  dma_chan_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_calc (
    .page_i   (sel_page),
    .base_a_i (sel_base_a),
    .cur_a_i  (sel_cur_a),
    .base_c_i (sel_base_c),
    .cur_c_i  (sel_cur_c),
    .wide_i   (sel_wide),
    .reload_i (sel_mode.reload),
    .phys_o   (calc_phys),
    .nxt_a_o  (calc_nxt_a),
    .nxt_c_o  (calc_nxt_c),
    .stop_o   (calc_stop),
    .cross_o  (calc_cross)
  );

  assign tc_set = (state_q == ST_XFER && s_stop) ? (NUM_CH'(1) << s_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      hrq_q      <= 1'b0;
      xfer_q     <= 1'b0;
      dack_q     <= '0;
      tc_q       <= 1'b0;
      phys_q     <= '0;
      to_mem_q   <= 1'b0;
      wide_q     <= 1'b0;
      err_q      <= 1'b0;
      upd_q      <= 1'b0;
      upd_ch_q   <= '0;
      upd_addr_q <= '0;
      upd_cnt_q  <= '0;
      s_ch       <= '0;
      s_stop     <= 1'b0;
      s_nxt_a    <= '0;
      s_nxt_c    <= '0;
    end else begin
      xfer_q <= 1'b0;
      tc_q   <= 1'b0;
      err_q  <= 1'b0;
      upd_q  <= 1'b0;
      hrq_q  <= (state_q == ST_XFER && s_stop) ? 1'b0 : |elig;
      case (state_q)
        ST_IDLE: begin
          if (hlda_i) state_q <= ST_ARB;
        end
        ST_ARB: begin
          if (!found) begin
            state_q <= ST_IDLE;
          end else if (!mode_ok(sel_mode) || calc_cross) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q  <= ST_XFER;
            xfer_q   <= 1'b1;
            tc_q     <= calc_stop;
            dack_q   <= NUM_CH'(1) << pick;
            phys_q   <= calc_phys;
            to_mem_q <= (sel_mode.xtype == XT_TO_MEM);
            wide_q   <= sel_wide;
            s_ch     <= pick;
            s_stop   <= calc_stop;
            s_nxt_a  <= calc_nxt_a;
            s_nxt_c  <= calc_nxt_c;
          end
        end
        ST_XFER: begin
          state_q    <= ST_DONE;
          upd_q      <= 1'b1;
          upd_ch_q   <= s_ch;
          upd_addr_q <= s_nxt_a;
          upd_cnt_q  <= s_nxt_c;
          if (s_stop) dack_q <= '0;
        end
        default: begin
          state_q <= ST_IDLE;
          dack_q  <= '0;
        end
      endcase
    end
  end

  generate
    for (genvar c = 0; c < NUM_CTL; c++) begin : g_stat
      assign status_o[c*2*CH_PER_CTL +: 2*CH_PER_CTL] =
        {req_v[c*CH_PER_CTL +: CH_PER_CTL], tc_v[c*CH_PER_CTL +: CH_PER_CTL]};
    end
  endgenerate

  assign hrq_o      = hrq_q;
  assign xfer_o     = xfer_q;
  assign dack_o     = dack_q;
  assign tc_o       = tc_q;
  assign phys_o     = phys_q;
  assign to_mem_o   = to_mem_q;
  assign wide_o     = wide_q;
  assign err_o      = err_q;
  assign upd_o      = upd_q;
  assign upd_ch_o   = upd_ch_q;
  assign upd_addr_o = upd_addr_q;
  assign upd_cnt_o  = upd_cnt_q;

endmodule

// File: rtl/dma_cascade_seq_chk.sv
`timescale 1ns/1ps
module dma_cascade_seq_chk #(
  parameter int CH_PER_CTL = 4,
  parameter int NUM_CTL    = 2,
  localparam int NUM_CH    = CH_PER_CTL * NUM_CTL,
  localparam int STAT_W    = NUM_CTL * 2 * CH_PER_CTL
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] drq_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic              hrq_o,
  input logic [NUM_CH-1:0] dack_o,
  input logic              tc_o,
  input logic              xfer_o,
  input logic              wide_o,
  input logic              err_o,
  input logic              upd_o,
  input logic [STAT_W-1:0] status_o
);

  logic [NUM_CH-1:0] req_v;
  logic [NUM_CH-1:0] tc_v;

  always_comb begin
    for (int c = 0; c < NUM_CTL; c++) begin
      for (int j = 0; j < CH_PER_CTL; j++) begin
        req_v[c*CH_PER_CTL+j] = status_o[c*2*CH_PER_CTL+CH_PER_CTL+j];
        tc_v[c*CH_PER_CTL+j]  = status_o[c*2*CH_PER_CTL+j];
      end
    end
  end

  p_req_track_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (req_v == $past(drq_i)));

  p_dack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack_o));

  p_xfer_one_dack_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> ($countones(dack_o) == 1));

  p_pick_eligible_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> ((dack_o & $past(req_v) & ~$past(mask_i)) == dack_o));

  p_tc_with_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> xfer_o);

  p_tc_release_r7: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> (dack_o == '0) && !hrq_o && ((tc_v & $past(dack_o)) == $past(dack_o)));

  p_width_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> (wide_o == ((dack_o >> CH_PER_CTL) != '0)));

  p_err_no_xfer_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !xfer_o && !upd_o && (dack_o == '0));

  p_xfer_then_upd_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> upd_o && !xfer_o);

  p_upd_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o && !xfer_o);

endmodule

bind dma_cascade_seq dma_cascade_seq_chk #(
  .CH_PER_CTL(CH_PER_CTL),
  .NUM_CTL   (NUM_CTL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .drq_i    (drq_i),
  .mask_i   (mask_i),
  .hrq_o    (hrq_o),
  .dack_o   (dack_o),
  .tc_o     (tc_o),
  .xfer_o   (xfer_o),
  .wide_o   (wide_o),
  .err_o    (err_o),
  .upd_o    (upd_o),
  .status_o (status_o)
);

// File: tb/dma_cascade_seq_bench.sv
`timescale 1ns/1ps
module dma_cascade_seq_bench;

  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NCH-1:0]    drq;
  logic [NCH-1:0]    mask;
  logic              hlda;
  logic [5:0]        md [NCH];
  logic [7:0]        pg [NCH];
  logic [15:0]       ba [NCH];
  logic [15:0]       bc [NCH];
  logic [15:0]       ca [NCH];
  logic [15:0]       cc [NCH];

  logic [NCH*6-1:0]  mode_f;
  logic [NCH*8-1:0]  page_f;
  logic [NCH*16-1:0] ba_f, ca_f, bc_f, cc_f;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      mode_f[i*6 +: 6]  = md[i];
      page_f[i*8 +: 8]  = pg[i];
      ba_f[i*16 +: 16]  = ba[i];
      ca_f[i*16 +: 16]  = ca[i];
      bc_f[i*16 +: 16]  = bc[i];
      cc_f[i*16 +: 16]  = cc[i];
    end
  end

  logic        hrq, xfer, tc, to_mem, wide, err, upd;
  logic [7:0]  dack;
  logic [23:0] phys;
  logic [2:0]  upd_ch;
  logic [15:0] upd_addr, upd_cnt, status;

  dma_cascade_seq u_dma_cascade_seq (
    .clk(clk), .rst(rst), .drq_i(drq), .hlda_i(hlda), .mask_i(mask),
    .mode_i(mode_f), .page_i(page_f), .base_addr_i(ba_f), .cur_addr_i(ca_f),
    .base_cnt_i(bc_f), .cur_cnt_i(cc_f), .hrq_o(hrq), .xfer_o(xfer),
    .dack_o(dack), .tc_o(tc), .phys_o(phys), .to_mem_o(to_mem),
    .wide_o(wide), .err_o(err), .upd_o(upd), .upd_ch_o(upd_ch),
    .upd_addr_o(upd_addr), .upd_cnt_o(upd_cnt), .status_o(status)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic cmp(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // programming requests, applied by the model process (single writer)
  int         p_seq = 0;
  int         p_done = 0;
  int         p_ch = 0;
  logic [7:0] p_pg;
  logic [15:0] p_ba, p_bc;
  logic [5:0] p_md;

  // reference model state
  int          m_ph, m_ch, pick;
  logic [7:0]  m_req, m_tc, elig;
  logic        m_stop, nhrq, bad, w;
  logic [15:0] m_na, m_nc;
  logic        e_hrq, e_xfer, e_tc, e_mem, e_wide, e_err, e_upd;
  logic [7:0]  e_dack;
  logic [23:0] e_phys;
  logic [2:0]  e_uch;
  logic [15:0] e_ua, e_uc;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_req = '0; m_tc = '0; m_ch = 0; m_stop = 0;
      e_hrq = 0; e_xfer = 0; e_tc = 0; e_err = 0; e_upd = 0; e_dack = '0;
      e_mem = 0; e_wide = 0; e_phys = '0; e_uch = '0; e_ua = '0; e_uc = '0;
      m_na = '0; m_nc = '0;
    end else begin
      elig = m_req & ~mask;
      nhrq = |elig;
      e_xfer = 0; e_tc = 0; e_err = 0; e_upd = 0;
      case (m_ph)
        0: if (hlda) m_ph = 1;
        1: begin
          m_ph = 0;
          pick = -1;
          for (int i = NCH - 1; i >= 0; i--) if (elig[i]) pick = i;
          if (pick >= 0) begin
            bad = (md[pick][5:4] > 2'd1) || md[pick][3] ||
                  (md[pick][1:0] == 2'd0) || (md[pick][1:0] == 2'd3) ||
                  (int'(ba[pick]) + int'(bc[pick]) > 65535);
            if (bad) e_err = 1;
            else begin
              m_ph = 2; e_xfer = 1; m_ch = pick;
              e_dack = 8'd1 << pick;
              w = (pick >= 4);
              e_phys = {pg[pick], 16'h0} | ({8'h0, ca[pick]} << w);
              e_mem = (md[pick][1:0] == 2'd1);
              e_wide = w;
              if (cc[pick] == 16'h0 && md[pick][2]) begin
                m_na = ba[pick]; m_nc = bc[pick];
              end else begin
                m_na = ca[pick] + 16'd1; m_nc = cc[pick] - 16'd1;
              end
              m_stop = (cc[pick] == 16'h0) && !md[pick][2];
              e_tc = m_stop;
            end
          end
        end
        2: begin
          m_ph = 3; e_upd = 1; e_uch = 3'(m_ch); e_ua = m_na; e_uc = m_nc;
          ca[m_ch] = m_na; cc[m_ch] = m_nc;
          if (m_stop) begin m_tc[m_ch] = 1'b1; e_dack = '0; nhrq = 0; end
        end
        default: begin m_ph = 0; e_dack = '0; end
      endcase
      e_hrq = nhrq;
      m_req = drq;
    end
    if (p_seq != p_done) begin
      pg[p_ch] = p_pg; ba[p_ch] = p_ba; ca[p_ch] = p_ba;
      bc[p_ch] = p_bc; cc[p_ch] = p_bc; md[p_ch] = p_md;
      p_done = p_seq;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  int          n_x = 0, n_tc = 0, n_err = 0;
  logic [7:0]  last_dack = '0;
  logic [23:0] last_phys = '0;
  logic        last_wide = 0, last_mem = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      cmp("R12 strobe", xfer, e_xfer);
      cmp("R3 dack", dack, e_dack);
      cmp("R7 tc", tc, e_tc);
      cmp("R2 hrq", hrq, e_hrq);
      cmp("R10 err", err, e_err);
      cmp("R6 upd", upd, e_upd);
      cmp("R2 status", status, {m_req[7:4], m_tc[7:4], m_req[3:0], m_tc[3:0]});
      if (e_xfer) begin
        cmp("R5 phys", phys, e_phys);
        cmp("R9 to_mem", to_mem, e_mem);
        cmp("R9 wide", wide, e_wide);
      end
      if (e_upd) begin
        cmp("R6 upd channel", upd_ch, e_uch);
        cmp("R6 upd addr", upd_addr, e_ua);
        cmp("R8 upd count", upd_cnt, e_uc);
      end
      if (xfer) begin
        n_x++; last_dack = dack; last_phys = phys; last_wide = wide; last_mem = to_mem;
      end
      if (tc) n_tc++;
      if (err) n_err++;
    end
  end

  task automatic prog(input int ch, input logic [7:0] pgv, input logic [15:0] bav,
                      input logic [15:0] bcv, input logic [5:0] mdv);
    @(negedge clk);
    p_ch = ch; p_pg = pgv; p_ba = bav; p_bc = bcv; p_md = mdv;
    p_seq++;
    @(negedge clk);
  endtask

  task automatic service();
    @(negedge clk) hlda = 1'b1;
    @(negedge clk) hlda = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  int x0, t0, r0;

  initial begin
    drq = '0; mask = '1; hlda = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      md[i] = '0; pg[i] = '0; ba[i] = '0; bc[i] = '0; ca[i] = '0; cc[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 xfer", xfer, 0);
    cmp("R1 dack", dack, 0);
    cmp("R1 hrq", hrq, 0);
    cmp("R1 status", status, 0);
    cmp("R1 upd", upd, 0);
    cmp("R1 err", err, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 first cycle", {hrq, xfer, upd, err, dack, status}, 0);

    // R6, R7: byte channel 2, three transfers, expiry on the third
    prog(2, 8'h12, 16'h3400, 16'd2, 6'b010001);
    mask[2] = 1'b0; drq[2] = 1'b1;
    repeat (3) @(negedge clk);
    x0 = n_x; t0 = n_tc;
    repeat (3) service();
    cmp("R6 transfer count", n_x - x0, 3);
    cmp("R7 tc pulses", n_tc - t0, 1);
    cmp("R7 tc flag ch2", status[2], 1);
    cmp("R9 direction type1", last_mem, 1);

    // R2: request flag clears after DRQ drops
    drq[2] = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R2 request cleared", status[6], 0);

    // R3, R5, R9: priority across banks
    prog(1, 8'h01, 16'h0100, 16'd10, 6'b010010);
    prog(3, 8'h03, 16'h0300, 16'd10, 6'b000001);
    prog(5, 8'h40, 16'h8001, 16'd5, 6'b010001);
    mask = 8'b1101_0101; drq = 8'b0010_1010;
    repeat (3) @(negedge clk);
    service();
    cmp("R3 lowest wins", last_dack, 8'h02);
    cmp("R9 type2 direction", last_mem, 0);
    mask[1] = 1'b1;
    service();
    cmp("R3 next eligible", last_dack, 8'h08);
    mask[3:0] = 4'hF;
    service();
    cmp("R3 second bank", last_dack, 8'h20);
    cmp("R5 word address", last_phys, 24'h410002);
    cmp("R9 word width", last_wide, 1);

    // R8: auto-reload on channel 6
    drq = '0; mask = '1;
    prog(6, 8'h07, 16'h0010, 16'd1, 6'b010110);
    mask[6] = 1'b0; drq[6] = 1'b1;
    repeat (3) @(negedge clk);
    t0 = n_tc; x0 = n_x;
    repeat (3) service();
    cmp("R8 no tc on reload", n_tc - t0, 0);
    cmp("R8 transfers", n_x - x0, 3);

    // R10: region crossing a 64K page
    drq = '0; mask = '1;
    prog(0, 8'h00, 16'hFFF0, 16'h0020, 6'b010001);
    mask[0] = 1'b0; drq[0] = 1'b1;
    repeat (3) @(negedge clk);
    r0 = n_err; x0 = n_x;
    service();
    cmp("R10 boundary error", n_err - r0, 1);
    cmp("R10 no transfer", n_x - x0, 0);

    // R11: illegal modes
    drq = '0; mask = '1;
    prog(7, 8'h02, 16'h0100, 16'd4, 6'b011001);
    mask[7] = 1'b0; drq[7] = 1'b1;
    repeat (3) @(negedge clk);
    r0 = n_err; x0 = n_x;
    service();
    prog(7, 8'h02, 16'h0100, 16'd4, 6'b010000);
    service();
    prog(7, 8'h02, 16'h0100, 16'd4, 6'b100001);
    service();
    cmp("R11 mode errors", n_err - r0, 3);
    cmp("R11 no transfer", n_x - x0, 0);

    // R4: everything masked
    mask = '1; drq = '1;
    repeat (3) @(negedge clk);
    r0 = n_err; x0 = n_x;
    service();
    cmp("R4 no transfer", n_x - x0, 0);
    cmp("R4 no error", n_err - r0, 0);
    cmp("R4 hrq low", hrq, 0);

    // R13: hold-acknowledge held through the walk
    drq = '0;
    prog(2, 8'h05, 16'h1000, 16'd8, 6'b010001);
    mask[2] = 1'b0; drq[2] = 1'b1;
    repeat (3) @(negedge clk);
    x0 = n_x;
    @(negedge clk) hlda = 1'b1;
    repeat (3) @(negedge clk);
    hlda = 1'b0;
    repeat (5) @(negedge clk);
    cmp("R13 single walk", n_x - x0, 1);
    cmp("R12 idle after walk", xfer | upd, 0);

    drq = '0;
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule